// File: doc/BRIEF.md
# Busy-Flag Converter Host Controller

This block is the host side of a serial link to a sampling converter that reports the end of each conversion by pulling its serial data line low, the busy flag. The controller raises the convert strobe for a fixed number of clocks, drops it, and then watches the synchronized data line for the falling edge that marks the end of conversion. That edge starts a read/write frame. The frame clocks out the next 14-bit configuration word and clocks in the 16-bit result, plus a 14-bit readback word when readback is enabled. The serial clock idles high, so polarity and phase are both 1. The host changes its output bit on falling edges and samples on the rising side.

The frame is always long enough to return the converter's output to its released state, so the busy flag can appear on the next conversion. The controller also tracks the converter's two-phase configuration pipeline. It repeats the power-up configuration once, marks the first two results invalid, and tags every result with the configuration word it was produced under. Results leave on a valid/ready output. A conversion that never signals completion is abandoned after a set number of clocks, and a sticky error flag is raised.

Top module: `bfc_host`

## Requirements
- R1: When `run` is high and no result is pending, `cnv` rises and stays high for exactly CNV_HIGH clocks, then stays low. A falling edge on `sdo` that happens while `cnv` is high is ignored and starts no frame.
- R2: `sck` idles high. Each frame produces exactly 17 falling `sck` edges, or 31 when READBACK=1, and never 16.
- R3: A frame starts only after a falling edge of the two-flop-synchronized `sdo` while `cnv` is low. `din` carries the 14-bit configuration word, MSB first, changing on falling edges 1 to 14, and is 0 afterwards.
- R4: The bits sampled on the rising side after falling edges 1 to 16 form `res_data`, MSB first. With READBACK=1, the bits after edges 17 to 30 form `res_rdbk`, MSB first. The bit after the last edge is discarded.
- R5: `res_ok` is 0 for the first two results after reset and 1 for every later one.
- R6: The configuration word written in the second frame after reset repeats the word written in the first frame, whatever `cfg_in` holds at that time.
- R7: For every result from the third onward, `res_cfg` equals the word written on `din` two frames earlier.
- R8: If no synchronized `sdo` falling edge arrives within TIMEOUT clocks after `cnv` falls, `timeout_err` rises exactly TIMEOUT clocks after that fall and stays high until reset. No result is produced, and with `run` high a new conversion starts.
- R9: While `res_valid` is high and `res_ready` is low, the result fields hold steady and `cnv` stays low.
- R10: While `run` is low, no new `cnv` pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Allows new conversions to start |
| cfg_in | input | 14 | Configuration word for the next frame |
| cnv | output | 1 | Convert strobe to the converter |
| sck | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial configuration data to the converter |
| sdo | input | 1 | Serial data and busy flag from the converter (released level is 1) |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 16 | Conversion result |
| res_rdbk | output | 14 | Readback word (0 when READBACK=0) |
| res_cfg | output | 14 | Configuration word the result belongs to |
| res_ok | output | 1 | Result is valid, i.e. not a power-up dummy |
| timeout_err | output | 1 | Sticky end-of-conversion timeout flag |

## Verification
The hardest case to reach is a converter that lowers its data line while the convert strobe is still high. A controller that looks for edges too early would treat this as an end of conversion. The bench model has a mode that lowers the line at the rising edge of the strobe and keeps it low. A correct controller then sees no edge, starts no frame, and times out at an exact clock count. The bench checks that count, checks that no frame was started, and checks that the pipeline numbering is unchanged when normal conversions resume. The power-up pipeline is checked as well: the second frame is given a `cfg_in` that is the bitwise inverse of the first word, so a missing repeat shows up directly.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
    localparam int DATA_W = 16;
    localparam int CFG_W  = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAIT,
        ST_FRAME,
        ST_HOLD
    } host_st_e;
endpackage

// File: rtl/bfc_sync.sv
module bfc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    always_comb ff_d = {ff_q[STAGES-2:0], d};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= {STAGES{RST_VAL}};
        else        ff_q <= ff_d;
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/bfc_frame.sv
module bfc_frame
    import bfc_pkg::*;
#(
    parameter int NBITS = 17,
    parameter int HALF  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] tx_word,
    input  logic             sdo_s,
    output logic             sck,
    output logic             din,
    output logic             busy,
    output logic             done,
    output logic [NBITS-2:0] rx_word
);
    localparam int BW = $clog2(NBITS + 1);
    localparam int HW = $clog2(HALF + 1);

    typedef struct packed {
        logic             sck;
        logic             din;
        logic             busy;
        logic             done;
        logic [BW-1:0]    nbit;
        logic [HW-1:0]    hcnt;
        logic [CFG_W-1:0] txsh;
        logic [NBITS-1:0] rxsh;
    } frm_t;

    frm_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sck  = 1'b0;
                d.nbit = BW'(1);
                d.hcnt = '0;
                d.din  = tx_word[CFG_W-1];
                d.txsh = {tx_word[CFG_W-2:0], 1'b0};
            end
        end else if (q.hcnt == HW'(HALF - 1)) begin
            d.hcnt = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
            end else begin
                // sample at the end of the high half, just before the next fall
                d.rxsh = {q.rxsh[NBITS-2:0], sdo_s};
                if (q.nbit == BW'(NBITS)) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.din  = 1'b0;
                end else begin
                    d.sck  = 1'b0;
                    d.nbit = q.nbit + BW'(1);
                    d.din  = q.txsh[CFG_W-1];
                    d.txsh = {q.txsh[CFG_W-2:0], 1'b0};
                end
            end
        end else begin
            d.hcnt = q.hcnt + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.sck <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck     = q.sck;
    assign din     = q.din;
    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_word = q.rxsh[NBITS-1:1];

    // falling-edge counter used only by the checks below
    logic [BW-1:0] falls_q;
    logic          sck_prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            falls_q    <= '0;
            sck_prev_q <= 1'b1;
        end else begin
            sck_prev_q <= q.sck;
            if (start && !q.busy)          falls_q <= '0;
            else if (sck_prev_q && !q.sck) falls_q <= falls_q + BW'(1);
        end
    end

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> falls_q == BW'(NBITS));
    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);
endmodule

// File: rtl/bfc_host.sv
module bfc_host
    import bfc_pkg::*;
#(
    parameter int SCK_HALF = 4,
    parameter int CNV_HIGH = 3,
    parameter int TIMEOUT  = 4096,
    parameter bit READBACK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CFG_W-1:0]  cfg_in,
    output logic              cnv,
    output logic              sck,
    output logic              din,
    input  logic              sdo,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic [CFG_W-1:0]  res_rdbk,
    output logic [CFG_W-1:0]  res_cfg,
    output logic              res_ok,
    output logic              timeout_err
);
    localparam int NBITS = READBACK ? (DATA_W + CFG_W + 1) : (DATA_W + 1);
    localparam int CMAX  = (TIMEOUT > CNV_HIGH) ? TIMEOUT : CNV_HIGH;
    localparam int CW    = $clog2(CMAX + 1);

    typedef struct packed {
        host_st_e          st;
        logic [CW-1:0]     cnt;
        logic [1:0]        conv;
        logic [CFG_W-1:0]  cfg1;
        logic [CFG_W-1:0]  cfg2;
        logic [CFG_W-1:0]  cfgw;
        logic              err;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic [CFG_W-1:0]  rrdbk;
        logic [CFG_W-1:0]  rcfg;
        logic              rok;
        logic              cnv;
        logic              sdo_prev;
    } host_t;

    host_t q, d;

    logic             sdo_s;
    logic             frm_start;
    logic             frm_done;
    logic             frm_busy;
    logic [CFG_W-1:0] frm_tx;
    logic [NBITS-2:0] rx_word;
    logic [CFG_W-1:0] rx_rdbk;

    bfc_sync #(.STAGES(2), .RST_VAL(1'b1)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(sdo), .q(sdo_s)
    );

    bfc_frame #(.NBITS(NBITS), .HALF(SCK_HALF)) frame_i (
        .clk(clk), .rst_n(rst_n), .start(frm_start), .tx_word(frm_tx),
        .sdo_s(sdo_s), .sck(sck), .din(din), .busy(frm_busy),
        .done(frm_done), .rx_word(rx_word)
    );

    generate
        if (READBACK) begin : g_rdbk
            assign rx_rdbk = rx_word[CFG_W-1:0];
        end else begin : g_nordbk
            assign rx_rdbk = '0;
        end
    endgenerate

    assign frm_start = (q.st == ST_WAIT) && q.sdo_prev && !sdo_s;
    assign frm_tx    = (q.conv == 2'd1) ? q.cfg1 : cfg_in;

    always_comb begin
        d          = q;
        d.sdo_prev = sdo_s;
        case (q.st)
            ST_IDLE: begin
                if (run) begin
                    d.st  = ST_CNV;
                    d.cnv = 1'b1;
                    d.cnt = '0;
                end
            end
            ST_CNV: begin
                if (q.cnt == CW'(CNV_HIGH - 1)) begin
                    d.cnv = 1'b0;
                    d.cnt = '0;
                    d.st  = ST_WAIT;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_WAIT: begin
                if (frm_start) begin
                    d.st   = ST_FRAME;
                    d.cfgw = frm_tx;
                end else if (q.cnt == CW'(TIMEOUT - 1)) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_FRAME: begin
                if (frm_done) begin
                    d.rvalid = 1'b1;
                    d.rdata  = rx_word[NBITS-2 -: DATA_W];
                    d.rrdbk  = rx_rdbk;
                    d.rok    = (q.conv == 2'd2);
                    d.rcfg   = q.cfg2;
                    d.cfg2   = q.cfg1;
                    d.cfg1   = q.cfgw;
                    if (q.conv != 2'd2) d.conv = q.conv + 2'd1;
                    d.st     = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (res_ready) begin
                    d.rvalid = 1'b0;
                    if (run) begin
                        d.st  = ST_CNV;
                        d.cnv = 1'b1;
                        d.cnt = '0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.sdo_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cnv         = q.cnv;
    assign res_valid   = q.rvalid;
    assign res_data    = q.rdata;
    assign res_rdbk    = q.rrdbk;
    assign res_cfg     = q.rcfg;
    assign res_ok      = q.rok;
    assign timeout_err = q.err;

    // R1
    edge_cnv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |-> !cnv && !frm_busy);
    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data)
            && $stable(res_cfg) && $stable(res_ok) && $stable(res_rdbk));
    // R9
    no_cnv_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cnv && sck);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);
endmodule

// File: tb/bfc_host_tb.sv
`timescale 1ns/1ps
module bfc_host_tb_top;
    localparam int HALF = 3;
    localparam int CNVH = 3;
    localparam int TMO  = 300;
    localparam bit RB   = 1'b1;
    localparam int NEDGE = RB ? 31 : 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        res_ready = 1'b0;
    logic        sdo = 1'b1;
    logic [13:0] cfg_in = '0;
    logic        cnv, sck, din, res_valid, res_ok, timeout_err;
    logic [15:0] res_data;
    logic [13:0] res_rdbk, res_cfg;

    always #2.5 clk = ~clk;

    bfc_host #(.SCK_HALF(HALF), .CNV_HIGH(CNVH), .TIMEOUT(TMO), .READBACK(RB)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_in(cfg_in), .cnv(cnv),
        .sck(sck), .din(din), .sdo(sdo), .res_valid(res_valid),
        .res_ready(res_ready), .res_data(res_data), .res_rdbk(res_rdbk),
        .res_cfg(res_cfg), .res_ok(res_ok), .timeout_err(timeout_err)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // converter model: mode 0 normal, 1 lowers sdo at the strobe rise
    int          mode_next = 0;
    int          m_mode = 0;
    int          m_j = 0;
    int          m_delay = 8;
    int          cnv_rises = 0;
    logic [15:0] m_data = '0;
    logic [13:0] m_rb = '0;
    logic [13:0] m_din = '0;

    always @(posedge cnv) begin
        cnv_rises++;
        m_mode = mode_next;
        mode_next = 0;
        m_j = 0;
        m_din = '0;
        m_data = 16'($urandom);
        m_rb = 14'($urandom);
        if (m_mode == 1) begin
            sdo = 1'b0;
        end else begin
            sdo = 1'b1;
            repeat (m_delay) @(posedge clk);
            sdo = 1'b0;
        end
    end

    always @(negedge sck) begin
        m_j++;
        if (m_j <= 16)            sdo = m_data[16-m_j];
        else if (RB && m_j <= 30) sdo = m_rb[30-m_j];
        else                      sdo = 1'b1;
    end

    always @(posedge sck) begin
        if (m_j >= 1 && m_j <= 14) m_din = {m_din[12:0], din};
    end

    // R1: strobe width
    int hl = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cnv) hl++;
            else if (hl != 0) begin
                chk(hl == CNVH, "R1 cnv high width", hl, CNVH);
                hl = 0;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        summary();
        $finish;
    end

    logic [13:0] exp_w [0:63];
    logic [13:0] cur_cfg;
    logic [15:0] held;
    bit          saw_valid;

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnv == 1'b0, "R1 reset cnv", cnv, 0);
        chk(sck == 1'b1, "R2 reset sck idle", sck, 1);
        chk(res_valid == 1'b0, "R9 reset res_valid", res_valid, 0);
        chk(timeout_err == 1'b0, "R8 reset err", timeout_err, 0);

        repeat (20) @(negedge clk);
        chk(cnv_rises == 0, "R10 idle with run low", cnv_rises, 0);

        // early edge while cnv high: ignored, then timeout (R1, R8)
        cur_cfg = 14'($urandom);
        cfg_in = cur_cfg;
        m_delay = 8;
        mode_next = 1;
        run = 1'b1;
        while (cnv !== 1'b1) @(negedge clk);
        while (cnv !== 1'b0) @(negedge clk);
        saw_valid = 1'b0;
        for (int k = 1; k <= TMO + 3; k++) begin
            @(negedge clk);
            if (res_valid) saw_valid = 1'b1;
            if (k == TMO - 3) chk(timeout_err == 1'b0, "R8 err not before timeout", timeout_err, 0);
            if (k == TMO - 1) chk(m_j == 0, "R1 no frame after early edge", m_j, 0);
        end
        chk(timeout_err == 1'b1, "R8 err after timeout", timeout_err, 1);
        chk(saw_valid == 1'b0, "R8 no result on timeout", saw_valid, 0);

        for (int n = 0; n < 40; n++) begin
            int lim;
            int rd;
            lim = 0;
            while (!res_valid && lim < 3000) begin
                @(negedge clk);
                lim++;
            end
            chk(res_valid == 1'b1, "R3 result arrives", res_valid, 1);
            exp_w[n] = (n == 1) ? exp_w[0] : cur_cfg;
            if (n == 1) chk(m_din == exp_w[0], "R6 power-up word repeated", m_din, exp_w[0]);
            else        chk(m_din == exp_w[n], "R3 din word", m_din, exp_w[n]);
            chk(res_data == m_data, "R4 data", res_data, m_data);
            chk(res_rdbk == m_rb, "R4 readback", res_rdbk, m_rb);
            chk(res_ok == (n >= 2), "R5 valid flag", res_ok, (n >= 2));
            if (n >= 2) chk(res_cfg == exp_w[n-2], "R7 config tag", res_cfg, exp_w[n-2]);
            chk(m_j == NEDGE, "R2 falling edges per frame", m_j, NEDGE);
            chk(sck == 1'b1, "R2 sck idle after frame", sck, 1);

            held = res_data;
            rd = int'($urandom % 4);
            for (int w = 0; w < rd; w++) begin
                @(negedge clk);
                chk(res_valid && res_data == held && !cnv, "R9 hold while not ready", res_data, held);
            end

            cur_cfg = (n == 0) ? ~exp_w[0] : 14'($urandom);
            cfg_in = cur_cfg;
            m_delay = (n % 7 == 3) ? 5 : 5 + int'($urandom % 50);
            if (n == 20) run = 1'b0;
            res_ready = 1'b1;
            @(negedge clk);
            res_ready = 1'b0;
            if (n == 20) begin
                int r0;
                r0 = cnv_rises;
                repeat (40) @(negedge clk);
                chk(cnv_rises == r0 && cnv == 1'b0, "R10 no conversion with run low", cnv_rises, r0);
                run = 1'b1;
            end
        end
        chk(timeout_err == 1'b1, "R8 err sticky", timeout_err, 1);
        summary();
        $finish;
    end
endmodule